// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Write Unlock

The block is a watchdog timer with a small register port. Software loads two preload values, sets the tick rate, enables the timer and then keeps it alive with periodic reload commands. A single down-counter first runs through the first-stage preload. When that stage runs out it can raise an interrupt and then counts down the second-stage preload. When the second stage runs out in watchdog mode, the block sets a sticky timeout flag and can assert a reset request. In timer mode the counter instead starts the first stage again.

The preload registers and the reload/flag register are protected. A protected write only takes effect directly after the two-byte unlock sequence. Each unlock admits one write. A lock bit can pin the enable on until the next hardware reset. There are two reset inputs. The power-on reset clears everything. The system reset, which is what the reset request normally drives, clears everything except the timeout flag, so that software can see after a restart why the restart happened.

Top module: `wdog2_top`

## Requirements
- R1: The unlock sequence is a write of 0x80 followed by a write of 0x86 to the reload register (address 2). Any other write to address 2 while the sequence is half done returns it to the start.
- R2: After an unlock, exactly one write to a protected register (address 0, 1 or 2) takes effect, and that write uses up the unlock. A write to preload 0 or 1 without an open unlock is ignored.
- R3: A protected write to address 2 with bit 8 set loads the counter from preload 1 and selects the first stage. It also restarts the prescaler from zero and drops the interrupt.
- R4: With first-stage preload P, the first stage expires on tick P+1 after a reload. The counter then takes the second-stage preload, and irq rises unless config bits 1:0 are both 1.
- R5: With second-stage preload Q, the second stage expires Q+1 ticks after the first stage. In watchdog mode this sets the timeout flag (bit 9 of address 2). It also asserts wdRst when config bit 5 is 0, and wdRst then stays high until a reset.
- R6: The timeout flag is cleared only by porN or by a protected write of 1 to bit 9 of address 2. rstN leaves the flag unchanged.
- R7: Lock register (address 3): bit 0 is lock, bit 1 is enable and bit 2 is mode. Once lock is set, writes to this register are ignored until a reset.
- R8: While enable is 0, the prescaler and the counter hold their values. Only a reload changes the counter.
- R9: Config bit 2 at 0 gives one tick every 2^SLOW_LOG2 clocks. Config bit 2 at 1 gives one tick every 2^FAST_LOG2 clocks, counted from the reload.
- R10: With lock bit 2 set (timer mode), the end of the second stage reloads preload 1 and starts the first stage again. In this mode neither the flag nor wdRst is set.
- R11: Reads are combinational. Address 0 returns preload 1, address 1 returns preload 2, address 2 returns the flag in bit 9, address 3 returns the lock bits, address 4 returns the config bits 5:0 and address 5 returns the counter. After reset the preloads read 15360, lock reads 0 and config reads 0x03.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low, clears all state |
| rstN | input | 1 | System reset, active low, keeps the timeout flag |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wrData | input | 20 | Write data |
| rdData | output | 20 | Read data for addr |
| irq | output | 1 | First-stage expiry interrupt (level) |
| wdRst | output | 1 | Reset request from second-stage expiry |

## Verification
A wrong unlock state shows up on the next read of a preload: a write that should have been blocked changes the value, or an accepted write leaves the old value. A wrong stage or counter value moves the irq or wdRst edge away from the clock cycle set by the preload and the tick length. The bench checks those edges on the exact cycle, one cycle before and at the edge. A wrong hold or lock behaviour appears in the counter readback or the lock readback at once.

// File: rtl/wdog2_pkg.sv
package wdog2_pkg;
  typedef enum logic [2:0] {
    ADDR_PRE1   = 3'd0,
    ADDR_PRE2   = 3'd1,
    ADDR_RELOAD = 3'd2,
    ADDR_LOCK   = 3'd3,
    ADDR_CFG    = 3'd4,
    ADDR_COUNT  = 3'd5
  } regAddr_e;

  typedef enum logic [1:0] {UL_IDLE, UL_HALF, UL_OPEN} unlock_e;
  typedef enum logic [1:0] {ST_FIRST, ST_SECOND, ST_DONE} stage_e;

  localparam int UNLOCK_FIRST  = 'h80;
  localparam int UNLOCK_SECOND = 'h86;
  localparam int RELOAD_BIT    = 8;
  localparam int FLAG_BIT      = 9;

  // control-to-datapath strobes and levels
  typedef struct packed {
    logic reload;
    logic clrFlag;
    logic enable;
    logic timerMode;
    logic fastTick;
    logic rstOutEn;
    logic irqEn;
  } wdStrobe_t;
endpackage

// File: rtl/wdog2_ctrl.sv
module wdog2_ctrl
  import wdog2_pkg::*;
#(
  parameter int DATA_W = 20,
  parameter logic [DATA_W-1:0] PRELOAD_RST = 20'd15360
) (
  input  logic              clk,
  input  logic              sysRstN,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] count,
  input  logic              flag,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] pre1,
  output logic [DATA_W-1:0] pre2,
  output wdStrobe_t         strobe
);
  localparam int LOCK_W = 3;
  localparam int CFG_W  = 6;

  unlock_e ulState, ulNext;
  logic [LOCK_W-1:0] lockR;
  logic [CFG_W-1:0]  cfgR;
  logic isReloadWr, isPreWr, protWr;

  assign isReloadWr = wrEn && (addr == ADDR_RELOAD);
  assign isPreWr    = wrEn && ((addr == ADDR_PRE1) || (addr == ADDR_PRE2));
  assign protWr     = (isReloadWr || isPreWr) && (ulState == UL_OPEN);

  always_comb begin
    ulNext = ulState;
    unique case (ulState)
      UL_IDLE: if (isReloadWr && wrData == DATA_W'(UNLOCK_FIRST)) ulNext = UL_HALF;
      UL_HALF: if (isReloadWr) ulNext = (wrData == DATA_W'(UNLOCK_SECOND)) ? UL_OPEN : UL_IDLE;
      UL_OPEN: if (isReloadWr || isPreWr) ulNext = UL_IDLE;
      default: ulNext = UL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      ulState <= UL_IDLE;
      pre1    <= PRELOAD_RST;
      pre2    <= PRELOAD_RST;
      lockR   <= '0;
      cfgR    <= CFG_W'(3);
    end else begin
      ulState <= ulNext;
      if (protWr && addr == ADDR_PRE1) pre1 <= wrData;
      if (protWr && addr == ADDR_PRE2) pre2 <= wrData;
      if (wrEn && addr == ADDR_LOCK && !lockR[0]) lockR <= wrData[LOCK_W-1:0];
      if (wrEn && addr == ADDR_CFG) cfgR <= wrData[CFG_W-1:0];
    end
  end

  always_comb begin
    strobe.reload    = protWr && isReloadWr && wrData[RELOAD_BIT];
    strobe.clrFlag   = protWr && isReloadWr && wrData[FLAG_BIT];
    strobe.enable    = lockR[1];
    strobe.timerMode = lockR[2];
    strobe.fastTick  = cfgR[2];
    strobe.rstOutEn  = !cfgR[5];
    strobe.irqEn     = (cfgR[1:0] != 2'b11);
  end

  always_comb begin
    unique case (addr)
      ADDR_PRE1:   rdData = pre1;
      ADDR_PRE2:   rdData = pre2;
      ADDR_RELOAD: rdData = DATA_W'({flag, 9'd0});
      ADDR_LOCK:   rdData = DATA_W'(lockR);
      ADDR_CFG:    rdData = DATA_W'(cfgR);
      ADDR_COUNT:  rdData = count;
      default:     rdData = '0;
    endcase
  end

  // R7: lock pins the enable on until reset
  assert_lock_holds_enable_R7: assert property (@(posedge clk) disable iff (!sysRstN)
    lockR[0] |=> (lockR[0] && lockR[1]));
  // R2: preload writes without an open unlock leave both preloads alone
  assert_blocked_preload_R2: assert property (@(posedge clk) disable iff (!sysRstN)
    (isPreWr && ulState != UL_OPEN) |=> ($stable(pre1) && $stable(pre2)));
  // R2: an accepted protected write closes the unlock
  assert_single_use_R2: assert property (@(posedge clk) disable iff (!sysRstN)
    (isPreWr && ulState == UL_OPEN) |=> (ulState == UL_IDLE));
endmodule

// File: rtl/wdog2_dp.sv
module wdog2_dp
  import wdog2_pkg::*;
#(
  parameter int DATA_W    = 20,
  parameter int SLOW_LOG2 = 15,
  parameter int FAST_LOG2 = 5,
  parameter logic [DATA_W-1:0] PRELOAD_RST = 20'd15360
) (
  input  logic              clk,
  input  logic              sysRstN,
  input  logic              porN,
  input  wdStrobe_t         strobe,
  input  logic [DATA_W-1:0] pre1,
  input  logic [DATA_W-1:0] pre2,
  output logic [DATA_W-1:0] count,
  output logic              flag,
  output logic              irq,
  output logic              wdRst
);
  stage_e stage;
  logic [SLOW_LOG2-1:0] preCnt;
  logic tick, cntZero, expireWd;

  assign tick = strobe.enable &&
                (strobe.fastTick ? (&preCnt[FAST_LOG2-1:0]) : (&preCnt));
  assign cntZero  = (count == '0);
  assign expireWd = tick && !strobe.reload && stage == ST_SECOND && cntZero && !strobe.timerMode;

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) preCnt <= '0;
    else if (strobe.reload) preCnt <= '0;
    else if (strobe.enable) preCnt <= preCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      count <= PRELOAD_RST;
      stage <= ST_FIRST;
      irq   <= 1'b0;
      wdRst <= 1'b0;
    end else if (strobe.reload) begin
      count <= pre1;
      stage <= ST_FIRST;
      irq   <= 1'b0;
    end else if (tick) begin
      unique case (stage)
        ST_FIRST:
          if (cntZero) begin
            stage <= ST_SECOND;
            count <= pre2;
            if (strobe.irqEn) irq <= 1'b1;
          end else count <= count - 1'b1;
        ST_SECOND:
          if (!cntZero) count <= count - 1'b1;
          else if (strobe.timerMode) begin
            stage <= ST_FIRST;
            count <= pre1;
          end else begin
            stage <= ST_DONE;
            if (strobe.rstOutEn) wdRst <= 1'b1;
          end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) flag <= 1'b0;
    else if (expireWd) flag <= 1'b1;
    else if (strobe.clrFlag) flag <= 1'b0;
  end

  // R8: no counting while disabled
  assert_hold_when_off_R8: assert property (@(posedge clk) disable iff (!sysRstN)
    (!strobe.enable && !strobe.reload) |=> $stable(count));
  // R5: reset request is held until a reset
  assert_rst_sticky_R5: assert property (@(posedge clk) disable iff (!sysRstN)
    wdRst |=> wdRst);
  // R6: flag only falls on a clear strobe
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!porN)
    (flag && !strobe.clrFlag) |=> flag);
  // R4: interrupt rises only out of the first stage
  assert_irq_from_first_R4: assert property (@(posedge clk) disable iff (!sysRstN)
    $rose(irq) |-> $past(stage == ST_FIRST));
endmodule

// File: rtl/wdog2_top.sv
module wdog2_top
  import wdog2_pkg::*;
#(
  parameter int DATA_W    = 20,
  parameter int SLOW_LOG2 = 15,
  parameter int FAST_LOG2 = 5,
  parameter logic [DATA_W-1:0] PRELOAD_RST = 20'd15360
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              wdRst
);
  logic sysRstN, flag;
  logic [DATA_W-1:0] pre1, pre2, count;
  wdStrobe_t strobe;

  assign sysRstN = rstN & porN;

  wdog2_ctrl #(.DATA_W(DATA_W), .PRELOAD_RST(PRELOAD_RST)) ctrl_i (
    .clk(clk), .sysRstN(sysRstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .count(count), .flag(flag), .rdData(rdData), .pre1(pre1), .pre2(pre2),
    .strobe(strobe));

  wdog2_dp #(.DATA_W(DATA_W), .SLOW_LOG2(SLOW_LOG2), .FAST_LOG2(FAST_LOG2),
             .PRELOAD_RST(PRELOAD_RST)) dp_i (
    .clk(clk), .sysRstN(sysRstN), .porN(porN), .strobe(strobe),
    .pre1(pre1), .pre2(pre2), .count(count), .flag(flag), .irq(irq),
    .wdRst(wdRst));
endmodule

// File: tb/wdog2_top_tb_top.sv
module wdog2_top_tb_top;
  localparam int DW = 20;
  logic clk = 1'b0, porN = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [2:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic irq, wdRst;
  int nChecks = 0, nFails = 0;

  always #5 clk = ~clk;

  wdog2_top #(.DATA_W(DW), .SLOW_LOG2(4), .FAST_LOG2(2)) dut_i (
    .clk(clk), .porN(porN), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq), .wdRst(wdRst));

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; addr = 3'(a); wrData = DW'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    addr = 3'(a);
    #1;
    v = int'(rdData);
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic unlock();
    wr(2, 'h80);
    wr(2, 'h86);
  endtask

  task automatic setPreloads();
    unlock(); wr(0, 3);
    unlock(); wr(1, 2);
  endtask

  task automatic sysReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
  endtask

  task automatic testReset();
    int v;
    check("R11 irq after reset", irq, 0);
    check("R11 wdRst after reset", wdRst, 0);
    rd(4, v); check("R11 config reset", v, 'h03);
    rd(3, v); check("R11 lock reset", v, 0);
    rd(0, v); check("R11 preload reset", v, 15360);
    rd(2, v); check("R6 flag cleared by porN", v, 0);
  endtask

  task automatic testUnlock();
    int v;
    wr(0, 7);
    rd(0, v); check("R2 write without unlock ignored", v, 15360);
    unlock(); wr(0, 3);
    rd(0, v); check("R1 unlocked write accepted", v, 3);
    wr(0, 9);
    rd(0, v); check("R2 second write needs new unlock", v, 3);
    wr(2, 'h80); wr(2, 'h55); wr(2, 'h86); wr(0, 11);
    rd(0, v); check("R1 broken sequence cancels unlock", v, 3);
    unlock(); wr(1, 2);
    rd(1, v); check("R1 preload 2 written", v, 2);
  endtask

  task automatic testSlowExpiry();
    int v;
    wr(4, 'h00); wr(3, 'h02);
    unlock(); wr(2, 'h100);
    rd(5, v); check("R3 counter from preload 1", v, 3);
    waitEdges(63); check("R4 irq before first expiry", irq, 0);
    waitEdges(1);  check("R4 irq at first expiry (R9 slow tick)", irq, 1);
    rd(5, v); check("R4 counter from preload 2", v, 2);
    waitEdges(47); check("R5 wdRst before second expiry", wdRst, 0);
    waitEdges(1);  check("R5 wdRst at second expiry", wdRst, 1);
    rd(2, v); check("R5 timeout flag set", v, 'h200);
  endtask

  task automatic testSysReset();
    int v;
    sysReset();
    check("R5 wdRst dropped by reset", wdRst, 0);
    rd(2, v); check("R6 flag survives rstN", v, 'h200);
    unlock(); wr(2, 'h200);
    rd(2, v); check("R6 flag cleared by write", v, 0);
  endtask

  task automatic testFastAndHold();
    int v;
    setPreloads();
    wr(4, 'h04); wr(3, 'h02);
    unlock(); wr(2, 'h100);
    waitEdges(15); check("R9 irq before fast expiry", irq, 0);
    waitEdges(1);  check("R9 irq at fast expiry", irq, 1);
    unlock(); wr(2, 'h100);
    check("R3 reload drops irq", irq, 0);
    rd(5, v); check("R3 reload counter", v, 3);
    waitEdges(9);
    wr(3, 'h00);
    rd(5, v); check("R8 counter after two ticks", v, 1);
    waitEdges(50);
    rd(5, v); check("R8 counter held while disabled", v, 1);
    check("R8 no irq while disabled", irq, 0);
  endtask

  task automatic testNoRstOut();
    int v;
    wr(4, 'h24); wr(3, 'h02);
    unlock(); wr(2, 'h100);
    waitEdges(30);
    check("R5 wdRst masked by config bit 5", wdRst, 0);
    rd(2, v); check("R5 flag set with output masked", v, 'h200);
  endtask

  task automatic testTimerMode();
    int v;
    wr(4, 'h04); wr(3, 'h06);
    unlock(); wr(2, 'h300);
    rd(2, v); check("R6 combined clear and reload", v, 0);
    waitEdges(40);
    check("R10 no wdRst in timer mode", wdRst, 0);
    rd(2, v); check("R10 no flag in timer mode", v, 0);
    rd(5, v); check("R10 first stage restarted", v, 0);
  endtask

  task automatic testLock();
    int v;
    wr(3, 'h03);
    wr(3, 'h00);
    rd(3, v); check("R7 lock keeps enable", v, 'h03);
    sysReset();
    rd(3, v); check("R7 lock released by reset", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    porN = 1'b1; rstN = 1'b1;
    @(negedge clk);
    testReset();
    testUnlock();
    testSlowExpiry();
    testSysReset();
    testFastAndHold();
    testNoRstOut();
    testTimerMode();
    testLock();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule